// File: doc/BRIEF.md
# Serial Character Transmitter with Modem Flow Control

This block serializes characters onto an asynchronous line. A one-character holding buffer takes a write from the host while a second character is shifted out, and the line timing comes from a single-cycle bit-rate tick.

Normally the tick runs at sixteen times the bit rate. A mode input switches it to one tick per bit for an external clock. Character length is 5 to 8 bits. Parity is optional, odd or even. The stop interval is programmed in sixteenth-of-a-bit steps.

Two flow-control features are built in:
- **Clear-to-send gating:** when enabled, a character starts only while the active-low clear-to-send input is asserted.
- **Automatic request-to-send drop:** the request-to-send level can be negated automatically once a block of characters has fully left the line after a disable was requested. It can also be set and cleared by explicit commands.

A host enables the transmitter and writes characters whenever `txrdy_o` is high. After the last character of a block it issues a disable. The transmitter drains both the buffer and the shifter, then shuts off. If auto mode is selected, it drops request-to-send one bit time later, which marks the end of the block to the far end.

Top module: `sio_tx`

## Requirements
- R1: After reset `txd_o`=1, `txrdy_o`=0, `txemt_o`=0 and `rts_o`=0.
- R2: A pulse on `tx_en_i` gives `txrdy_o`=1 and `txemt_o`=1 (underrun) in the next cycle. A write is taken only while `txrdy_o`=1, and a write while `txrdy_o`=0 is dropped. One character may wait in the buffer while another is shifted, and the two go out back to back.
- R3: A frame has four parts, in this order:
  - a start bit of 0;
  - the data bits, LSB first, with count 5 + `char_len_i` (code 0..3);
  - a parity bit if `par_en_i`=1, equal to the XOR of the data bits when `par_odd_i`=0 and to its inverse when `par_odd_i`=1;
  - the stop interval at 1.
  
  With `x1_mode_i`=0 every bit lasts 16 ticks. `txd_o` is 1 whenever nothing is being sent.
- R4: For `char_len_i` 1..3 (6 to 8 bits), the stop interval is 9 + `stop_sel_i` ticks for codes 0..7 and 17 + `stop_sel_i` ticks for codes 8..15.
- R5: For `char_len_i`=0 (5 bits), the stop interval is 17 + `stop_sel_i` ticks.
- R6: With `x1_mode_i`=1 each bit lasts one tick. The stop interval is 1 tick when `stop_sel_i[3]`=0 and 2 ticks when it is 1.
- R7: With `cts_gate_i`=1, a character starts only while `cts_ni`=0, and `txd_o` stays 1 while it waits. With `cts_gate_i`=0, `cts_ni` has no effect.
- R8: A change on `cts_ni` after a character has started changes neither its bits nor its length.
- R9: `tx_dis_i` drives `txrdy_o` to 0 in the next cycle. The character in the shifter and the one in the buffer are still sent in full. After that `txd_o`=1, `txrdy_o`=0 and `txemt_o`=0.
- R10: `rts_set_i` drives `rts_o` to 1 and `rts_clr_i` drives it to 0 in the next cycle. If both are high, set wins.
- R11: With `rts_auto_i`=1, `rts_o` falls at the 16th tick after the tick that ends the last stop interval of a pending disable. With `rts_auto_i`=0, a disable leaves `rts_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | bit-rate tick, 16 per bit, or 1 per bit when `x1_mode_i`=1 |
| x1_mode_i | input | 1 | 1: external 1x clock mode |
| wr_i | input | 1 | write strobe for `wdata_i` |
| wdata_i | input | DATA_W | character to send |
| tx_en_i | input | 1 | enable command |
| tx_dis_i | input | 1 | disable command |
| rts_set_i | input | 1 | set request-to-send |
| rts_clr_i | input | 1 | clear request-to-send |
| cts_gate_i | input | 1 | 1: gate each character start with clear-to-send |
| rts_auto_i | input | 1 | 1: drop request-to-send after disable drain |
| stop_sel_i | input | 4 | stop length code |
| char_len_i | input | 2 | character length code, 0..3 = 5..8 bits |
| par_en_i | input | 1 | parity enable |
| par_odd_i | input | 1 | 1: odd parity |
| cts_ni | input | 1 | clear-to-send, active low |
| txd_o | output | 1 | serial output, 1 = mark |
| txrdy_o | output | 1 | buffer can take a write |
| txemt_o | output | 1 | buffer and shifter both empty while enabled |
| rts_o | output | 1 | request-to-send level, 1 = asserted |

## Verification
The bench builds the block with its default parameters: an 8-bit buffer, 16 ticks per bit and a two-stage clear-to-send synchronizer. The tick is driven once every four clocks. That width reaches all four character lengths, and the 16x division makes the 9/16 and 32/16 stop limits measurable to the exact tick. Spacing the ticks apart from the clock lets the bench count ticks between the start edge, the end of the stop interval and the request-to-send drop, so off-by-one errors in the stop timing and the bit-time timer show up as tick-count mismatches.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_st_e;
endpackage

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      full_o <= 1'b1;
      data_o <= data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_tx_stop.sv
module sio_tx_stop #(
  parameter int OVS = 16,
  parameter int CW  = 6
) (
  input  logic          x1_i,
  input  logic [1:0]    len_i,
  input  logic [3:0]    sel_i,
  output logic [CW-1:0] ticks_o
);
  localparam logic [CW-1:0] BASE_LONG  = CW'(OVS + 1);
  localparam logic [CW-1:0] BASE_SHORT = CW'(OVS / 2 + 1);

  always_comb begin
    if (x1_i)
      ticks_o = sel_i[3] ? CW'(2) : CW'(1);
    else if (len_i == 2'd0 || sel_i[3])
      ticks_o = BASE_LONG + CW'(sel_i);
    else
      ticks_o = BASE_SHORT + CW'(sel_i);
  end
endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift
  import sio_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int CW     = 6,
  parameter int NB_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [NB_W-1:0]   ld_nbits_i,
  input  logic              ld_par_en_i,
  input  logic              ld_par_odd_i,
  input  logic [CW-1:0]     ld_stop_i,
  input  logic              ld_x1_i,
  output logic              busy_o,
  output logic              txd_o
);
  tx_st_e            st_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [NB_W-1:0]   left_q;
  logic              par_q, par_en_q, x1_q;
  logic [CW-1:0]     stop_q;
  logic [DATA_W-1:0] mask;
  logic              par_nxt;
  logic [CW-1:0]     bt;
  logic              bit_end, stop_end;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (NB_W'(i) < ld_nbits_i);
    par_nxt = (^(ld_data_i & mask)) ^ ld_par_odd_i;
  end

  assign bt       = x1_q ? CW'(1) : CW'(OVS);
  assign bit_end  = tick_i && (cnt_q == bt - CW'(1));
  assign stop_end = tick_i && (cnt_q == stop_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      left_q   <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
      x1_q     <= 1'b0;
      stop_q   <= CW'(1);
    end else begin
      unique case (st_q)
        ST_IDLE: if (ld_i) begin
          st_q     <= ST_START;
          cnt_q    <= '0;
          sh_q     <= ld_data_i;
          left_q   <= ld_nbits_i;
          par_q    <= par_nxt;
          par_en_q <= ld_par_en_i;
          x1_q     <= ld_x1_i;
          stop_q   <= ld_stop_i;
        end
        ST_START: begin
          if (bit_end) begin
            st_q  <= ST_DATA;
            cnt_q <= '0;
          end else if (tick_i) cnt_q <= cnt_q + CW'(1);
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q  <= '0;
            sh_q   <= sh_q >> 1;
            left_q <= left_q - NB_W'(1);
            if (left_q == NB_W'(1)) st_q <= par_en_q ? ST_PAR : ST_STOP;
          end else if (tick_i) cnt_q <= cnt_q + CW'(1);
        end
        ST_PAR: begin
          if (bit_end) begin
            st_q  <= ST_STOP;
            cnt_q <= '0;
          end else if (tick_i) cnt_q <= cnt_q + CW'(1);
        end
        ST_STOP: begin
          if (stop_end) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (tick_i) cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/sio_tx_rts.sv
module sio_tx_rts #(
  parameter int OVS = 16,
  parameter int CW  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic x1_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic arm_i,
  output logic rts_o
);
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] bt;

  assign bt = x1_i ? CW'(1) : CW'(OVS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_o <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (set_i) begin
      rts_o <= 1'b1;
      run_q <= 1'b0;
    end else if (clr_i) begin
      rts_o <= 1'b0;
      run_q <= 1'b0;
    end else if (arm_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && tick_i) begin
      // one bit time after drain, then negate
      if (cnt_q == bt - CW'(1)) begin
        rts_o <= 1'b0;
        run_q <= 1'b0;
      end else cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              x1_mode_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_en_i,
  input  logic              tx_dis_i,
  input  logic              rts_set_i,
  input  logic              rts_clr_i,
  input  logic              cts_gate_i,
  input  logic              rts_auto_i,
  input  logic [3:0]        stop_sel_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              cts_ni,
  output logic              txd_o,
  output logic              txrdy_o,
  output logic              txemt_o,
  output logic              rts_o
);
  localparam int CW   = $clog2(2 * OVS + 1);
  localparam int NB_W = $clog2(DATA_W + 1);

  logic              en_q, pend_q;
  logic              hold_full, busy, ld, wr_acc, drain_done, cts_sync;
  logic [DATA_W-1:0] hold_data;
  logic [CW-1:0]     stop_ticks;
  logic [NB_W-1:0]   nbits;
  logic [SYNC_N-1:0] cts_sq;

  // clear-to-send synchronizer, resets to negated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cts_sq <= '1;
    else         cts_sq <= {cts_sq[SYNC_N-2:0], cts_ni};
  end
  assign cts_sync = cts_sq[SYNC_N-1];

  assign drain_done = pend_q && !busy && !hold_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (tx_dis_i) begin
      pend_q <= en_q;
    end else if (tx_en_i) begin
      en_q   <= 1'b1;
      pend_q <= 1'b0;
    end else if (drain_done) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end
  end

  assign txrdy_o = en_q && !pend_q && !hold_full;
  assign txemt_o = en_q && !busy && !hold_full;
  assign wr_acc  = wr_i && txrdy_o;
  assign ld      = hold_full && !busy && (!cts_gate_i || !cts_sync);
  assign nbits   = NB_W'(5) + NB_W'(char_len_i);

  sio_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_acc),
    .data_i (wdata_i),
    .take_i (ld),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  sio_tx_stop #(.OVS(OVS), .CW(CW)) u_stop (
    .x1_i    (x1_mode_i),
    .len_i   (char_len_i),
    .sel_i   (stop_sel_i),
    .ticks_o (stop_ticks)
  );

  sio_tx_shift #(.DATA_W(DATA_W), .OVS(OVS), .CW(CW), .NB_W(NB_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .ld_i         (ld),
    .ld_data_i    (hold_data),
    .ld_nbits_i   (nbits),
    .ld_par_en_i  (par_en_i),
    .ld_par_odd_i (par_odd_i),
    .ld_stop_i    (stop_ticks),
    .ld_x1_i      (x1_mode_i),
    .busy_o       (busy),
    .txd_o        (txd_o)
  );

  sio_tx_rts #(.OVS(OVS), .CW(CW)) u_rts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .x1_i   (x1_mode_i),
    .set_i  (rts_set_i),
    .clr_i  (rts_clr_i),
    .arm_i  (drain_done && rts_auto_i),
    .rts_o  (rts_o)
  );
endmodule

// File: rtl/sio_tx_chk.sv
module sio_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic tx_dis_i,
  input logic rts_set_i,
  input logic rts_clr_i,
  input logic cts_gate_i,
  input logic cts_q_i,
  input logic busy_i,
  input logic txd_o,
  input logic txrdy_o,
  input logic txemt_o,
  input logic rts_o
);
  assert_idle_mark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txemt_o |-> txd_o);

  assert_wr_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && txrdy_o) |=> !txrdy_o);

  assert_cts_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cts_gate_i && cts_q_i) |=> txd_o);

  assert_dis_rdy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dis_i |=> !txrdy_o);

  assert_rts_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_set_i |=> rts_o);

  assert_rts_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_clr_i && !rts_set_i) |=> !rts_o);
endmodule

bind sio_tx sio_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .tx_dis_i   (tx_dis_i),
  .rts_set_i  (rts_set_i),
  .rts_clr_i  (rts_clr_i),
  .cts_gate_i (cts_gate_i),
  .cts_q_i    (cts_sync),
  .busy_i     (busy),
  .txd_o      (txd_o),
  .txrdy_o    (txrdy_o),
  .txemt_o    (txemt_o),
  .rts_o      (rts_o)
);

// File: tb/sio_tx_bench.sv
module sio_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int WDOG       = 150000;
  localparam int NVEC       = 8;
  // {data, len, par_en, par_odd, stop_sel, x1}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 4'h7, 1'b0},
    {8'h3C, 2'd2, 1'b1, 1'b0, 4'h0, 1'b0},
    {8'h5A, 2'd1, 1'b1, 1'b1, 4'hF, 1'b0},
    {8'h13, 2'd0, 1'b0, 1'b0, 4'h0, 1'b0},
    {8'hFF, 2'd0, 1'b1, 1'b1, 4'h8, 1'b0},
    {8'h81, 2'd3, 1'b1, 1'b0, 4'h8, 1'b0},
    {8'h6E, 2'd3, 1'b0, 1'b0, 4'h0, 1'b1},
    {8'hC3, 2'd2, 1'b1, 1'b1, 4'h9, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, x1 = 1'b0;
  logic wr = 1'b0, en = 1'b0, dis = 1'b0, rset = 1'b0, rclr = 1'b0;
  logic cgate = 1'b0, rauto = 1'b0, pe = 1'b0, po = 1'b0, cts_n = 1'b1;
  logic [7:0] wdata = '0;
  logic [3:0] ssel = '0;
  logic [1:0] clen = 2'd3;
  logic txd, txrdy, txemt, rts;
  int total = 0, bad = 0, tick_cnt = 0, cyc = 0;

  sio_tx u_sio_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .x1_mode_i(x1),
    .wr_i(wr), .wdata_i(wdata), .tx_en_i(en), .tx_dis_i(dis),
    .rts_set_i(rset), .rts_clr_i(rclr), .cts_gate_i(cgate), .rts_auto_i(rauto),
    .stop_sel_i(ssel), .char_len_i(clen), .par_en_i(pe), .par_odd_i(po),
    .cts_ni(cts_n), .txd_o(txd), .txrdy_o(txrdy), .txemt_o(txemt), .rts_o(rts)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tick) tick_cnt <= tick_cnt + 1;
  end

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick = (div == TDIV - 1);
      div  = (div == TDIV - 1) ? 0 : div + 1;
    end
  end

  initial begin
    wait (cyc >= WDOG);
    bad++; total++;
    $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, WDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] l, input logic p);
    return 1 + 5 + int'(l) + int'(p);
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic [1:0] l,
                                            input logic p, input logic o);
    logic [10:0] v = '0;
    logic par = o;
    int n = 5 + int'(l);
    for (int i = 0; i < n; i++) begin
      v[1+i] = d[i];
      par ^= d[i];
    end
    if (p) v[1+n] = par;
    return v;
  endfunction

  function automatic int exp_stop(input logic [1:0] l, input logic [3:0] s, input logic m);
    if (m) return s[3] ? 2 : 1;
    if (l == 2'd0 || s[3]) return 17 + int'(s);
    return 9 + int'(s);
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // capture one frame; cts_k >= 0 raises cts_n at that bit
  task automatic capture(input int nb, input int bt, input bit wait_end, input int cts_k,
                         output logic [10:0] bits, output int t0, output int ticks);
    bits = '0;
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_cnt;
    for (int k = 0; k < nb; k++) begin
      while (tick_cnt < t0 + bt * k + bt / 2) @(negedge clk);
      bits[k] = txd;
      if (k == cts_k) cts_n = 1'b1;
    end
    if (wait_end) begin
      while (txemt !== 1'b1) @(negedge clk);
      ticks = tick_cnt - t0;
    end else begin
      while (tick_cnt < t0 + bt * nb) @(negedge clk);
      ticks = 0;
    end
  endtask

  task automatic stay_mark(input int nt, input string req);
    bit seen0 = 0;
    int t = tick_cnt;
    while (tick_cnt < t + nt) begin
      @(negedge clk);
      if (txd !== 1'b1) seen0 = 1;
    end
    check(!seen0, req, int'(seen0), 0);
  endtask

  initial begin
    logic [10:0] got, expv, mask;
    int t0, tk, nb, bt, t1;
    logic [7:0] d;
    logic [1:0] l;
    logic p, o, m;
    logic [3:0] s;

    repeat (3) @(negedge clk);
    check(txd === 1'b1 && txrdy === 1'b0 && txemt === 1'b0 && rts === 1'b0, "R1 reset",
          {txd, txrdy, txemt, rts}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // write while disabled is dropped
    put(8'h55);
    stay_mark(40, "R2 write while disabled");
    pulse(en);
    check(txrdy === 1'b1 && txemt === 1'b1, "R2 underrun after enable", {txrdy, txemt}, 2'b11);

    for (int i = 0; i < NVEC; i++) begin
      {d, l, p, o, s, m} = VEC[i];
      @(negedge clk);
      clen = l; pe = p; po = o; ssel = s; x1 = m;
      nb = nbits_of(l, p);
      bt = m ? 1 : 16;
      put(d);
      capture(nb, bt, 1'b1, -1, got, t0, tk);
      mask = 11'((1 << nb) - 1);
      expv = exp_frame(d, l, p, o);
      check((got & mask) === expv, m ? "R6 bits x1" : "R3 bits", int'(got & mask), int'(expv));
      check(tk == bt * nb + exp_stop(l, s, m),
            m ? "R6 stop" : (l == 2'd0 ? "R5 stop" : "R4 stop"),
            tk, bt * nb + exp_stop(l, s, m));
      check(txd === 1'b1, "R3 idle mark", int'(txd), 1);
    end

    // buffered back to back, extra write while full dropped
    @(negedge clk);
    x1 = 0; clen = 2'd3; pe = 0; ssel = 4'h7;
    put(8'h11);
    repeat (2) @(negedge clk);
    put(8'h22);
    put(8'h33);
    capture(9, 16, 1'b0, -1, got, t0, tk);
    check(got[8:1] === 8'h11, "R2 first of pair", int'(got[8:1]), 8'h11);
    capture(9, 16, 1'b1, -1, got, t0, tk);
    check(got[8:1] === 8'h22, "R2 buffered second", int'(got[8:1]), 8'h22);
    stay_mark(40, "R2 write while full dropped");

    // CTS gating
    @(negedge clk); cgate = 1'b1; cts_n = 1'b1;
    put(8'h96);
    stay_mark(30, "R7 waits on cts");
    check(txrdy === 1'b0 && txemt === 1'b0, "R7 buffer held", {txrdy, txemt}, 2'b00);
    @(negedge clk); cts_n = 1'b0;
    capture(9, 16, 1'b1, 3, got, t0, tk);
    check(got[8:0] === {8'h96, 1'b0}, "R8 bits with cts change", int'(got[8:0]), 9'h12C);
    check(tk == 9 * 16 + 16, "R8 length with cts change", tk, 160);
    @(negedge clk); cgate = 1'b0;
    put(8'h0F);
    capture(9, 16, 1'b1, -1, got, t0, tk);
    check(got[8:1] === 8'h0F, "R7 cts ignored when gate off", int'(got[8:1]), 8'h0F);

    // RTS commands
    pulse(rset);
    check(rts === 1'b1, "R10 set", int'(rts), 1);
    pulse(rclr);
    check(rts === 1'b0, "R10 clear", int'(rts), 0);
    @(negedge clk); rset = 1'b1; rclr = 1'b1;
    @(negedge clk); rset = 1'b0; rclr = 1'b0;
    check(rts === 1'b1, "R10 set wins", int'(rts), 1);

    // disable with buffered char and auto RTS
    @(negedge clk); rauto = 1'b1;
    put(8'hC5);
    repeat (2) @(negedge clk);
    put(8'h3A);
    @(negedge clk); dis = 1'b1;
    @(negedge clk); dis = 1'b0;
    check(txrdy === 1'b0, "R9 rdy low on disable", int'(txrdy), 0);
    capture(9, 16, 1'b0, -1, got, t0, tk);
    check(got[8:1] === 8'hC5, "R9 current char sent", int'(got[8:1]), 8'hC5);
    capture(9, 16, 1'b1, -1, got, t0, tk);
    check(got[8:1] === 8'h3A, "R9 held char sent", int'(got[8:1]), 8'h3A);
    t1 = t0 + tk;
    while (tick_cnt < t1 + 15) @(negedge clk);
    check(rts === 1'b1, "R11 rts before bit time", int'(rts), 1);
    while (tick_cnt < t1 + 16) @(negedge clk);
    check(rts === 1'b0, "R11 rts after bit time", int'(rts), 0);
    check(txd === 1'b1 && txrdy === 1'b0 && txemt === 1'b0, "R9 off after drain",
          {txd, txrdy, txemt}, 3'b100);

    // disable without auto keeps RTS
    @(negedge clk); rauto = 1'b0;
    pulse(en);
    pulse(rset);
    put(8'h77);
    pulse(dis);
    capture(9, 16, 1'b1, -1, got, t0, tk);
    t1 = t0 + tk;
    while (tick_cnt < t1 + 40) @(negedge clk);
    check(rts === 1'b1, "R11 no auto keeps rts", int'(rts), 1);
    check(txemt === 1'b0 && txrdy === 1'b0, "R9 off without auto", {txrdy, txemt}, 2'b00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule